// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block fetches a run of consecutive 16-bit words from a three-wire-plus-select serial EEPROM of the Microwire kind. A single `start` pulse captures a first word address and a word count. For every word the block opens a fresh transaction. It raises chip select with the serial clock held low for a setup interval, gives one idle clock period, sends the start bit and the read opcode, and then sends the address. After that it clocks in seventeen reply bits and closes the transaction again before it moves on to the next address.

Each fetched word leaves the block on a one-cycle `word_valid` strobe, together with its offset from the first address. `done` pulses once after the last word, and `busy` covers the whole run. The serial clock is built from three cycle counts: the low time, the high time and the chip-select setup time. The address width is fixed at elaboration to 6 or 8 bits.

Top module: `uwire_seq_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sclk`, `ee_di`, `busy`, `done` and `word_valid` are all 0.
- R2: Each word transaction begins with `ee_cs` rising while `ee_sclk` is low. `ee_sclk` then stays low for exactly `CS_CYC` cycles and gives one full clock period, with `ee_di` = 0, before the start bit.
- R3: After that preamble the bits presented on `ee_di` at successive rising edges of `ee_sclk` are 1, 1, 0: the start bit, then read opcode `10`. They are followed by the `AW`-bit word address, most significant bit first.
- R4: Seventeen bits are clocked in per word. The first is a dummy zero and is discarded, so `word_data` holds the next sixteen bits with the first received in bit 15.
- R5: `ee_do` is sampled in the last low cycle of the serial clock, immediately before a rising edge. The memory changes `ee_do` right after each rising edge.
- R6: While `ee_cs` is high, every high phase of `ee_sclk` lasts `HI_CYC` cycles. Every low phase after the preamble lasts `LO_CYC` cycles.
- R7: Between two words, `ee_cs` stays low for `LO_CYC + HI_CYC + LO_CYC` cycles. This interval contains one full serial clock period with select low.
- R8: Word k of a run (k = 0 .. count-1) is read from address (`start_addr` + k) mod 2^`AW` and carries `word_index` = k.
- R9: `word_valid` is high for a single cycle per word, and `word_data` changes only in a cycle where `word_valid` is high.
- R10: `busy` rises in the cycle after an accepted `start` and falls when `done` rises. `ee_cs` is never high without `busy`. A `start` seen while busy has no effect.
- R11: A `start` with `word_count` = 0 gives `done` in the next cycle, and `busy` and `ee_cs` stay low.
- R12: For a count n > 0, `done` rises exactly n × (`CS_CYC` + `HI_CYC` + (21 + `AW`) × (`LO_CYC` + `HI_CYC`) + `LO_CYC`) cycles after the edge that accepts `start`. `done` stays high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| start_addr | input | AW | First word address |
| word_count | input | AW+1 | Number of words to read |
| ee_cs | output | 1 | Memory chip select |
| ee_sclk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data from the memory |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| word_valid | output | 1 | One-cycle strobe per fetched word |
| word_data | output | 16 | Fetched word |
| word_index | output | AW | Offset of the word from `start_addr` |

## Verification
Every serial slot lasts a fixed number of system cycles with no gaps between slots. Because of that, the bench derives the cycle of each result from the divider counts. The reply word is strobed in the same edge as the seventeenth sample. `done` is due n × 144 cycles after the accepting edge with the bench's dividers (2 low, 3 high, 4 setup, 6 address bits), and after exactly one cycle for a zero count. The checks sample at falling edges of the system clock. A running cycle counter is compared against these closed-form delays. A memory model reacts to the serial clock and measures every phase width against its own divider count.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

   localparam int WORD_W  = 16;
   localparam int CMD_LEN = 3;
   // start bit followed by the read opcode, sent from bit 2 down
   localparam logic [CMD_LEN-1:0] READ_CMD = 3'b110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_CMD,
      ST_ADDR,
      ST_READ,
      ST_TEAR,
      ST_GAP
   } uwr_state_e;

   typedef enum logic [1:0] {
      P_OFF,
      P_LOW,
      P_HIGH
   } uwr_phase_e;

endpackage

// File: rtl/uwr_pacer.sv
module uwr_pacer
   import uwr_pkg::*;
#(
   parameter int LO_CYC = 63,
   parameter int HI_CYC = 188,
   parameter int CS_CYC = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic long_low,
   input  logic low_only,
   output logic sclk,
   output logic sample,
   output logic slot_end
);

   localparam int MAX_CYC = (CS_CYC > LO_CYC) ? ((CS_CYC > HI_CYC) ? CS_CYC : HI_CYC)
                                             : ((LO_CYC > HI_CYC) ? LO_CYC : HI_CYC);
   localparam int CW = $clog2(MAX_CYC + 1);

   if (LO_CYC < 1 || HI_CYC < 1 || CS_CYC < 1) begin : g_bad_div
      $error("uwr_pacer: divider counts must be at least 1");
   end

   uwr_phase_e      phase, phase_n;
   logic [CW-1:0]   cnt, cnt_n;
   logic            lo_only_q;
   logic            last;

   assign last     = (cnt == '0);
   assign sample   = (phase == P_LOW) && last;
   assign slot_end = last && ((phase == P_HIGH) || ((phase == P_LOW) && lo_only_q));

   always_comb begin
      phase_n = phase;
      cnt_n   = cnt;
      if (launch) begin
         phase_n = P_LOW;
         cnt_n   = long_low ? CW'(CS_CYC - 1) : CW'(LO_CYC - 1);
      end else begin
         case (phase)
            P_LOW: begin
               if (last) begin
                  phase_n = lo_only_q ? P_OFF : P_HIGH;
                  cnt_n   = CW'(HI_CYC - 1);
               end else begin
                  cnt_n = cnt - CW'(1);
               end
            end
            P_HIGH: begin
               if (last) phase_n = P_OFF;
               else      cnt_n   = cnt - CW'(1);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= P_OFF;
         cnt       <= '0;
         lo_only_q <= 1'b0;
         sclk      <= 1'b0;
      end else begin
         phase <= phase_n;
         cnt   <= cnt_n;
         sclk  <= (phase_n == P_HIGH);
         if (launch) lo_only_q <= low_only;
      end
   end

   AST_SAMPLE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sample |-> !sclk); // R5

   AST_LAUNCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> ((phase == P_OFF) || slot_end)); // R6

   AST_HIGH_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == P_HIGH) |-> sclk); // R6

endmodule

// File: rtl/uwr_shreg.sv
module uwr_shreg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q
);

   if (W < 2) begin : g_bad_w
      $error("uwr_shreg: width must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic nxt;
      if (i == 0) begin : g_in
         assign nxt = din;
      end else begin : g_chain
         assign nxt = q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= 1'b0;
         else if (shift) q[i] <= nxt;
      end
   end

endmodule

// File: rtl/uwire_seq_reader.sv
module uwire_seq_reader
   import uwr_pkg::*;
#(
   parameter int AW     = 6,
   parameter int LO_CYC = 63,
   parameter int HI_CYC = 188,
   parameter int CS_CYC = 250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [AW-1:0]     start_addr,
   input  logic [AW:0]       word_count,
   output logic              ee_cs,
   output logic              ee_sclk,
   output logic              ee_di,
   input  logic              ee_do,
   output logic              busy,
   output logic              done,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic [AW-1:0]     word_index
);

   localparam int RD_BITS = WORD_W + 1;
   localparam int CNT_W   = AW + 1;
   localparam int BIT_W   = $clog2(RD_BITS);
   localparam logic [BIT_W-1:0] LAST_RD  = BIT_W'(RD_BITS - 1);
   localparam logic [BIT_W-1:0] LAST_CMD = BIT_W'(CMD_LEN - 1);
   localparam logic [BIT_W-1:0] TOP_ADR  = BIT_W'(AW - 1);

   if (AW != 6 && AW != 8) begin : g_bad_aw
      $error("uwire_seq_reader: AW must be 6 or 8");
   end

   uwr_state_e          st;
   logic [BIT_W-1:0]    bit_q;
   logic [AW-1:0]       addr_q, asr_q;
   logic [CMD_LEN-1:0]  csr_q;
   logic [CNT_W-1:0]    left_q;
   logic                launch, long_low, low_only;
   logic                sample, slot_end;
   logic                accept, finish, rd_shift;
   logic [WORD_W-1:0]   sh_q;

   assign accept   = (st == ST_IDLE) && start && (word_count != '0);
   assign finish   = (st == ST_GAP) && slot_end && (left_q == CNT_W'(1));
   assign launch   = accept || (slot_end && !finish);
   assign long_low = (st == ST_IDLE) || (st == ST_GAP);
   assign low_only = (st == ST_TEAR);
   assign rd_shift = sample && (st == ST_READ);

   uwr_pacer #(
      .LO_CYC (LO_CYC),
      .HI_CYC (HI_CYC),
      .CS_CYC (CS_CYC)
   ) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .long_low (long_low),
      .low_only (low_only),
      .sclk     (ee_sclk),
      .sample   (sample),
      .slot_end (slot_end)
   );

   uwr_shreg #(
      .W (WORD_W)
   ) u_shreg (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (rd_shift),
      .din   (ee_do),
      .q     (sh_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bit_q      <= '0;
         addr_q     <= '0;
         asr_q      <= '0;
         csr_q      <= '0;
         left_q     <= '0;
         ee_cs      <= 1'b0;
         ee_di      <= 1'b0;
         busy       <= 1'b0;
         done       <= 1'b0;
         word_valid <= 1'b0;
         word_data  <= '0;
         word_index <= '0;
      end else begin
         done       <= 1'b0;
         word_valid <= 1'b0;
         if (rd_shift && (bit_q == LAST_RD)) begin
            word_valid <= 1'b1;
            word_data  <= {sh_q[WORD_W-2:0], ee_do};
         end
         case (st)
            ST_IDLE: begin
               if (start) begin
                  if (word_count == '0) begin
                     done <= 1'b1;
                  end else begin
                     st         <= ST_PRE;
                     busy       <= 1'b1;
                     ee_cs      <= 1'b1;
                     ee_di      <= 1'b0;
                     addr_q     <= start_addr;
                     left_q     <= word_count;
                     word_index <= '0;
                  end
               end
            end
            ST_PRE: begin
               if (slot_end) begin
                  st    <= ST_CMD;
                  bit_q <= '0;
                  ee_di <= READ_CMD[CMD_LEN-1];
                  csr_q <= READ_CMD << 1;
               end
            end
            ST_CMD: begin
               if (slot_end) begin
                  if (bit_q == LAST_CMD) begin
                     st    <= ST_ADDR;
                     bit_q <= TOP_ADR;
                     ee_di <= addr_q[AW-1];
                     asr_q <= addr_q << 1;
                  end else begin
                     bit_q <= bit_q + BIT_W'(1);
                     ee_di <= csr_q[CMD_LEN-1];
                     csr_q <= csr_q << 1;
                  end
               end
            end
            ST_ADDR: begin
               if (slot_end) begin
                  if (bit_q == '0) begin
                     st    <= ST_READ;
                     ee_di <= 1'b0;
                  end else begin
                     bit_q <= bit_q - BIT_W'(1);
                     ee_di <= asr_q[AW-1];
                     asr_q <= asr_q << 1;
                  end
               end
            end
            ST_READ: begin
               if (slot_end) begin
                  if (bit_q == LAST_RD) begin
                     st    <= ST_TEAR;
                     ee_cs <= 1'b0;
                  end else begin
                     bit_q <= bit_q + BIT_W'(1);
                  end
               end
            end
            ST_TEAR: begin
               if (slot_end) st <= ST_GAP;
            end
            ST_GAP: begin
               if (slot_end) begin
                  if (left_q == CNT_W'(1)) begin
                     st   <= ST_IDLE;
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     st         <= ST_PRE;
                     ee_cs      <= 1'b1;
                     ee_di      <= 1'b0;
                     addr_q     <= addr_q + AW'(1);
                     left_q     <= left_q - CNT_W'(1);
                     word_index <= word_index + AW'(1);
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ee_cs |-> busy); // R10

   AST_CS_RISES_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs) |-> !ee_sclk); // R2

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid); // R9

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> $stable(word_data)); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12

   AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (word_count == '0)) |=> (done && !ee_cs && !busy)); // R11

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10

endmodule

// File: tb/uwire_seq_reader_test.sv
module uwire_seq_reader_test;

   localparam int AW  = 6;
   localparam int LO  = 2;
   localparam int HI  = 3;
   localparam int CSU = 4;
   localparam int NA  = 1 << AW;
   localparam int WCY = CSU + HI + (21 + AW) * (LO + HI) + LO;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [AW:0]   word_count = '0;
   logic          ee_cs, ee_sclk, ee_di;
   logic          ee_do = 1'b0;
   logic          busy, done, word_valid;
   logic [15:0]   word_data;
   logic [AW-1:0] word_index;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uwire_seq_reader #(
      .AW     (AW),
      .LO_CYC (LO),
      .HI_CYC (HI),
      .CS_CYC (CSU)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_addr (start_addr),
      .word_count (word_count),
      .ee_cs      (ee_cs),
      .ee_sclk    (ee_sclk),
      .ee_di      (ee_di),
      .ee_do      (ee_do),
      .busy       (busy),
      .done       (done),
      .word_valid (word_valid),
      .word_data  (word_data),
      .word_index (word_index)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic logic [15:0] pat(input int a);
      return 16'((a * 40503) ^ 23235 ^ (a << 11));
   endfunction

   // memory model
   int          m_ph = 0, m_nb = 0, m_zeros = 0;
   logic [1:0]  m_op = '0;
   logic [AW-1:0] m_addr = '0;
   logic [15:0] m_word = '0;

   always @(posedge ee_sclk or negedge ee_cs) begin
      if (!ee_cs) begin
         m_ph = 0; m_nb = 0; m_zeros = 0; ee_do = 1'b0;
      end else begin
         case (m_ph)
            0: begin
               if (ee_di) begin
                  chk(m_zeros == 1, "R2 preamble zero clocks", m_zeros, 1);
                  m_ph = 1; m_nb = 0;
               end else m_zeros++;
            end
            1: begin
               m_op = {m_op[0], ee_di};
               m_nb++;
               if (m_nb == 2) begin
                  chk(m_op == 2'b10, "R3 read opcode", int'(m_op), 2);
                  m_ph = 2; m_nb = 0;
               end
            end
            2: begin
               m_addr = {m_addr[AW-2:0], ee_di};
               m_nb++;
               if (m_nb == AW) begin
                  m_word = pat(int'(m_addr));
                  ee_do = 1'b0;
                  m_ph = 3; m_nb = 0;
               end
            end
            default: begin
               if (m_nb < 16) ee_do = m_word[15 - m_nb];
               else           ee_do = 1'b0;
               m_nb++;
            end
         endcase
      end
   end

   // waveform and word monitor
   int   hi_run = 0, lo_run = 0, cl_run = 0;
   bit   first_rise = 0, cl_armed = 0;
   logic p_sclk = 0, p_cs = 0, p_valid = 0;
   int   exp_idx = 0, run_sa = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!p_cs && ee_cs) begin
            if (cl_armed) chk(cl_run == LO + HI + LO, "R7 select low gap", cl_run, LO + HI + LO);
            cl_armed = 0; first_rise = 1; lo_run = 0;
         end
         if (p_cs && !ee_cs) begin
            cl_run = 0; cl_armed = 1;
         end
         if (p_sclk && !ee_sclk) begin
            chk(hi_run == HI, "R6 high width", hi_run, HI);
            hi_run = 0;
         end
         if (!p_sclk && ee_sclk && ee_cs) begin
            if (first_rise) chk(lo_run == CSU, "R2 select setup", lo_run, CSU);
            else            chk(lo_run == LO, "R6 low width", lo_run, LO);
            first_rise = 0; lo_run = 0;
         end
         if (ee_sclk) hi_run++;
         if (ee_cs && !ee_sclk) lo_run++;
         if (!ee_cs && busy) cl_run++;
         if (ee_cs) chk(busy, "R10 select within busy", int'(busy), 1);
         if (word_valid) begin
            chk(!p_valid, "R9 single strobe", int'(p_valid), 0);
            chk(int'(word_index) == exp_idx, "R8 word index", int'(word_index), exp_idx);
            chk(int'(m_addr) == (run_sa + exp_idx) % NA, "R3 R8 address sent",
                int'(m_addr), (run_sa + exp_idx) % NA);
            chk(word_data == pat((run_sa + exp_idx) % NA), "R4 R5 word data",
                int'(word_data), int'(pat((run_sa + exp_idx) % NA)));
            exp_idx++;
         end
         p_sclk = ee_sclk; p_cs = ee_cs; p_valid = word_valid;
      end
   end

   task automatic run(input int sa, input int n, input bit poke);
      int c0;
      int k;
      logic [15:0] held;
      exp_idx = 0;
      run_sa  = sa;
      @(negedge clk);
      start_addr = AW'(sa);
      word_count = (AW+1)'(n);
      start = 1'b1;
      c0 = cyc;
      @(negedge clk);
      start = 1'b0;
      if (n > 0) chk(busy, "R10 busy after start", int'(busy), 1);
      else chk(!busy && !ee_cs && done, "R11 zero count done", int'({busy, ee_cs, done}), 1);
      k = 0;
      while (!done) begin
         if (poke && k == 200) begin
            held = word_data;
            start_addr = AW'(sa + 17);
            word_count = (AW+1)'(3);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      chk(cyc - (c0 + 1) == n * WCY, "R12 run duration", cyc - (c0 + 1), n * WCY);
      chk(!busy, "R10 busy low at done", int'(busy), 0);
      chk(exp_idx == n, "R8 word count", exp_idx, n);
      @(negedge clk);
      chk(!done, "R12 done single cycle", int'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({ee_cs, ee_sclk, ee_di, busy, done, word_valid} == 6'b0, "R1 reset outputs",
          int'({ee_cs, ee_sclk, ee_di, busy, done, word_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ee_cs, ee_sclk, busy, done} == 4'b0, "R1 idle after reset",
          int'({ee_cs, ee_sclk, busy, done}), 0);
      run(0, 1, 0);
      run(5, 3, 0);
      run(62, 4, 0);           // R8 address wrap
      run(0, 0, 0);            // R11
      run(20, 2, 1);           // R10 start ignored while busy
      run(0, NA, 0);           // every address
      run(63, 1, 0);
      run(0, 0, 0);            // R11
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule